// File: doc/BRIEF.md
# Texture Mipmap Placement Sequencer

This block turns one 32-bit texture upload header into an ordered stream of region commands. Each command tells a downstream region writer where a block of texels goes inside texture memory and where that block starts in the source data. The command carries a destination corner (x, y), a width, a height and a byte offset into the source. Texture memory is two pages of 2048x1024 texels, stacked vertically into one 2048-high coordinate space.

The header fixes the base size, the base position, the page, the texel depth and an upload mode. The mode chooses what is emitted: the base level alone, the mip chain alone, or the base level followed by the chain. Each mip level is packed into a fixed corner area of the page. The packing uses a per-level corner and the base coordinates scaled down by a power of two. The block only generates these addresses. Texel data never passes through it.

A pulse on `start` with a valid header begins an upload. Commands leave on a valid/ready handshake. A one-cycle `done` pulse marks the end of the upload. Any `start` that arrives before that end is ignored.

Top module: `tex_mip_seq`

## Requirements
- R1: The base level is 2^(5+header[16:14]) texels wide and 2^(5+header[19:17]) texels high.
- R2: The base command is placed at x = header[5:0]*32 and y = header[11:7]*32 + 1024*header[20]. Its source offset is 0.
- R3: Mip level n (n = 0 for the first) is placed at x = XC[n] + (header[5:0]*32)/2^(n+1) and y = YC[n] + (header[11:7]*32)/2^(n+1) + 1024*header[20]. Here XC = 1024,1536,1792,1920,1984,2016,2032,2040,2044 and YC = 512,768,896,960,992,1008,1016,1020,1022.
- R4: Each mip level has half the width and half the height of the level before it. A further level follows only while both dimensions of the previous level exceed 8, so the smallest emitted dimension is 8.
- R5: header[27:24] = 0 emits the base level and then the mip chain. A value of 1 emits only the base level. A value of 2 emits only the mip chain.
- R6: Each command's source offset is the previous level's offset plus that level's width*height*B. B is 2 when header[23] is 1 and 1 when it is 0. In mode 2 the first mip level still starts past the base level, at base width*height*B.
- R7: A mode value other than 0, 1 or 2 produces no command, and `done` pulses in the cycle after `start` is taken.
- R8: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` stays high and every command field holds its value.
- R9: `done` is high for exactly one cycle. In the mode 0, 1 and 2 cases that cycle is the one after the last command is accepted, and `cmd_valid` is low in it.
- R10: A `start` pulse from the cycle it is taken until the `done` cycle, inclusive, is ignored. The first command appears in the cycle after `start` is taken.
- R11: In reset, `cmd_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an upload with `header` (taken only when idle) |
| header | input | 32 | Texture upload header |
| cmd_ready | input | 1 | Region writer accepts the current command |
| cmd_valid | output | 1 | A command is presented |
| cmd_x | output | 11 | Destination column |
| cmd_y | output | 11 | Destination row, page bit included as +1024 |
| cmd_w | output | 13 | Region width in texels |
| cmd_h | output | 13 | Region height in texels |
| cmd_off | output | 26 | Source byte offset of the region |
| done | output | 1 | One-cycle end-of-upload pulse |

## Verification
The assertions are checked on every cycle. They cover holding a stalled command, power-of-two region sizes no smaller than 8, source offsets that strictly increase between accepted commands, the single-cycle `done` pulse, and a command stream that only begins right after a `start`.

The exact coordinates from the corner tables, the length of each chain, the mode selection, the ignored-start window and the invalid-mode timing are shown only by the bench's scenarios. These scenarios include a largest-size texture on the upper page, non-square shapes, and random back-pressure. In each of them the bench compares every transfer against its own behavioural model.

// File: rtl/tms_pkg.sv
package tms_pkg;

  localparam int COORD_W = 11;                 // texel coordinate bits (2048)
  localparam int DIM_W   = 13;                 // region size bits (up to 4096)
  localparam int LOG_W   = 4;                  // log2 of a region size
  localparam int PAGE_X  = 1 << COORD_W;       // sheet width
  localparam int PAGE_H  = PAGE_X / 2;         // height of one page
  localparam int MIN_LOG = 3;                  // chain stops at size 8

  localparam logic [3:0] MODE_FULL = 4'd0;
  localparam logic [3:0] MODE_BASE = 4'd1;
  localparam logic [3:0] MODE_MIPS = 4'd2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BASE = 2'd1,
    ST_MIP  = 2'd2,
    ST_FIN  = 2'd3
  } tms_state_e;

  typedef struct packed {
    logic [5:0]       col;
    logic [4:0]       row;
    logic             page;
    logic             wide;
    logic [LOG_W-1:0] lw;
    logic [LOG_W-1:0] lh;
    logic [3:0]       mode;
  } tms_hdr_t;

  // corner column of mip level n
  function automatic logic [COORD_W-1:0] mip_corner_x(input logic [LOG_W-1:0] n);
    return COORD_W'(PAGE_X - ((PAGE_X / 2) >> n));
  endfunction

  // corner row of mip level n within a page
  function automatic logic [COORD_W-1:0] mip_corner_y(input logic [LOG_W-1:0] n);
    if (n >= LOG_W'(10)) return '0;
    return COORD_W'(PAGE_H - ((PAGE_H / 2) >> n));
  endfunction

endpackage

// File: rtl/tms_hdr_decode.sv
module tms_hdr_decode
  import tms_pkg::*;
(
  input  logic [31:0] hdr,
  output tms_hdr_t    fld
);

  logic unused_hdr_bits;
  assign unused_hdr_bits = ^{hdr[31:28], hdr[22:21], hdr[13:12], hdr[6]};

  always_comb begin
    fld.col  = hdr[5:0];
    fld.row  = hdr[11:7];
    fld.page = hdr[20];
    fld.wide = hdr[23];
    fld.lw   = LOG_W'(5) + LOG_W'(hdr[16:14]);
    fld.lh   = LOG_W'(5) + LOG_W'(hdr[19:17]);
    fld.mode = hdr[27:24];
  end

endmodule

// File: rtl/tms_level_place.sv
module tms_level_place
  import tms_pkg::*;
(
  input  logic [5:0]         col,
  input  logic [4:0]         row,
  input  logic               page,
  input  logic               is_mip,
  input  logic [LOG_W-1:0]   lvl,
  output logic [COORD_W-1:0] x,
  output logic [COORD_W-1:0] y
);

  logic [COORD_W-1:0] base_x, base_row, page_off;
  logic [LOG_W-1:0]   sh;

  always_comb begin
    base_x   = COORD_W'({col, 5'b0});
    base_row = COORD_W'({row, 5'b0});
    page_off = page ? COORD_W'(PAGE_H) : '0;
    sh       = lvl + LOG_W'(1);
    if (is_mip) begin
      x = mip_corner_x(lvl) + (base_x >> sh);
      y = mip_corner_y(lvl) + (base_row >> sh) + page_off;
    end else begin
      x = base_x;
      y = base_row + page_off;
    end
  end

endmodule

// File: rtl/tex_mip_seq.sv
module tex_mip_seq
  import tms_pkg::*;
#(
  parameter int OFF_W = 26
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [31:0]        header,
  input  logic               cmd_ready,
  output logic               cmd_valid,
  output logic [COORD_W-1:0] cmd_x,
  output logic [COORD_W-1:0] cmd_y,
  output logic [DIM_W-1:0]   cmd_w,
  output logic [DIM_W-1:0]   cmd_h,
  output logic [OFF_W-1:0]   cmd_off,
  output logic               done
);

  localparam int SH_W = LOG_W + 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  tms_hdr_t dec;
  tms_hdr_decode u_dec (.hdr(header), .fld(dec));

  tms_state_e       st_q, st_d;
  logic [5:0]       col_q, col_d;
  logic [4:0]       row_q, row_d;
  logic             page_q, page_d, wide_q, wide_d;
  logic [3:0]       mode_q, mode_d;
  logic [LOG_W-1:0] lvl_q, lvl_d, lw_q, lw_d, lh_q, lh_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic             ld_en, fire;

  function automatic logic [OFF_W-1:0] level_bytes(input logic [LOG_W-1:0] lw,
                                                   input logic [LOG_W-1:0] lh,
                                                   input logic wide);
    logic [SH_W-1:0] sh;
    sh = SH_W'(lw) + SH_W'(lh) + SH_W'(wide);
    return OFF_W'(1) << sh;
  endfunction

  assign cmd_valid = (st_q == ST_BASE) || (st_q == ST_MIP);
  assign done      = (st_q == ST_FIN);
  assign fire      = cmd_valid && cmd_ready;

  always_comb begin
    st_d   = st_q;
    col_d  = col_q;  row_d  = row_q;  page_d = page_q;
    wide_d = wide_q; mode_d = mode_q;
    lvl_d  = lvl_q;  lw_d   = lw_q;   lh_d   = lh_q;
    off_d  = off_q;
    ld_en  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        ld_en  = 1'b1;
        col_d  = dec.col;  row_d  = dec.row;  page_d = dec.page;
        wide_d = dec.wide; mode_d = dec.mode;
        lvl_d  = '0;
        lw_d   = dec.lw;
        lh_d   = dec.lh;
        off_d  = '0;
        case (dec.mode)
          MODE_FULL, MODE_BASE: st_d = ST_BASE;
          MODE_MIPS: begin
            st_d  = ST_MIP;
            lw_d  = dec.lw - LOG_W'(1);
            lh_d  = dec.lh - LOG_W'(1);
            off_d = level_bytes(dec.lw, dec.lh, dec.wide);
          end
          default: st_d = ST_FIN;
        endcase
      end
      ST_BASE: if (fire) begin
        ld_en = 1'b1;
        if (mode_q == MODE_BASE) begin
          st_d = ST_FIN;
        end else begin
          st_d  = ST_MIP;
          lw_d  = lw_q - LOG_W'(1);
          lh_d  = lh_q - LOG_W'(1);
          off_d = off_q + level_bytes(lw_q, lh_q, wide_q);
        end
      end
      ST_MIP: if (fire) begin
        ld_en = 1'b1;
        if (lw_q > LOG_W'(MIN_LOG) && lh_q > LOG_W'(MIN_LOG)) begin
          lvl_d = lvl_q + LOG_W'(1);
          lw_d  = lw_q - LOG_W'(1);
          lh_d  = lh_q - LOG_W'(1);
          off_d = off_q + level_bytes(lw_q, lh_q, wide_q);
        end else begin
          st_d = ST_FIN;
        end
      end
      ST_FIN: begin
        ld_en = 1'b1;
        st_d  = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      col_q  <= '0; row_q <= '0; page_q <= 1'b0; wide_q <= 1'b0;
      mode_q <= '0; lvl_q <= '0; lw_q   <= '0;   lh_q   <= '0;
      off_q  <= '0;
    end else if (ld_en) begin
      col_q  <= col_d;  row_q <= row_d; page_q <= page_d; wide_q <= wide_d;
      mode_q <= mode_d; lvl_q <= lvl_d; lw_q   <= lw_d;   lh_q   <= lh_d;
      off_q  <= off_d;
    end
  end

  tms_level_place u_place (
    .col    (col_q),
    .row    (row_q),
    .page   (page_q),
    .is_mip (st_q == ST_MIP),
    .lvl    (lvl_q),
    .x      (cmd_x),
    .y      (cmd_y)
  );

  assign cmd_w   = DIM_W'(1) << lw_q;
  assign cmd_h   = DIM_W'(1) << lh_q;
  assign cmd_off = off_q;

endmodule

// File: rtl/tex_mip_seq_chk.sv
module tex_mip_seq_chk
  import tms_pkg::*;
#(
  parameter int OFF_W = 26
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               cmd_ready,
  input logic               cmd_valid,
  input logic [COORD_W-1:0] cmd_x,
  input logic [COORD_W-1:0] cmd_y,
  input logic [DIM_W-1:0]   cmd_w,
  input logic [DIM_W-1:0]   cmd_h,
  input logic [OFF_W-1:0]   cmd_off,
  input logic               done
);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_x) && $stable(cmd_y)
      && $stable(cmd_w) && $stable(cmd_h) && $stable(cmd_off)));

  // R4
  size_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ($countones(cmd_w) == 1 && $countones(cmd_h) == 1
      && cmd_w >= DIM_W'(8) && cmd_h >= DIM_W'(8)));

  // R6
  off_rising_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (!cmd_valid || cmd_off > $past(cmd_off)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_valid);

  // R10
  stream_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> $past(start));

endmodule

bind tex_mip_seq tex_mip_seq_chk #(.OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cmd_ready(cmd_ready),
  .cmd_valid(cmd_valid), .cmd_x(cmd_x), .cmd_y(cmd_y), .cmd_w(cmd_w),
  .cmd_h(cmd_h), .cmd_off(cmd_off), .done(done)
);

// File: tb/tex_mip_seq_test.sv
module tex_mip_seq_test;

  typedef struct {
    int    x, y, w, h, off;
    string tag;
  } exp_cmd_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] header = '0;
  logic        cmd_ready = 1'b1;
  logic        cmd_valid, done;
  logic [10:0] cmd_x, cmd_y;
  logic [12:0] cmd_w, cmd_h;
  logic [25:0] cmd_off;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  bit mbusy = 0, done_due = 0, run_mon = 0, rand_rdy = 0, finished = 0;
  exp_cmd_t q[$];

  int XC[9] = '{1024, 1536, 1792, 1920, 1984, 2016, 2032, 2040, 2044};
  int YC[9] = '{512, 768, 896, 960, 992, 1008, 1016, 1020, 1022};

  tex_mip_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .header(header),
    .cmd_ready(cmd_ready), .cmd_valid(cmd_valid), .cmd_x(cmd_x), .cmd_y(cmd_y),
    .cmd_w(cmd_w), .cmd_h(cmd_h), .cmd_off(cmd_off), .done(done)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mk(input int mode, input int wide, input int sy,
                                     input int sx, input int page, input int row,
                                     input int col, input logic [3:0] junk);
    logic [31:0] h;
    h = '0;
    h[31:28] = junk;
    h[27:24] = mode[3:0];
    h[23]    = wide[0];
    h[20]    = page[0];
    h[19:17] = sy[2:0];
    h[16:14] = sx[2:0];
    h[11:7]  = row[4:0];
    h[5:0]   = col[5:0];
    h[13:12] = junk[1:0];
    h[6]     = junk[2];
    return h;
  endfunction

  // behavioural model: build the full expected command list
  task automatic expect_upload(input logic [31:0] h);
    int b, w, h0, bx, ry, pg, mode, off, mw, mh, n;
    exp_cmd_t e;
    b    = h[23] ? 2 : 1;
    w    = 32 << h[16:14];
    h0   = 32 << h[19:17];
    bx   = h[5:0] * 32;
    ry   = h[11:7] * 32;
    pg   = h[20] ? 1024 : 0;
    mode = h[27:24];
    if (mode == 0 || mode == 1) begin
      e.x = bx; e.y = ry + pg; e.w = w; e.h = h0; e.off = 0; e.tag = "R2";
      q.push_back(e);
    end
    if (mode == 0 || mode == 2) begin
      off = w * h0 * b; mw = w; mh = h0; n = 0;
      while (mw > 8 && mh > 8) begin
        mw = mw / 2; mh = mh / 2;
        e.x = XC[n] + bx / (2 << n);
        e.y = YC[n] + ry / (2 << n) + pg;
        e.w = mw; e.h = mh; e.off = off; e.tag = "R3";
        q.push_back(e);
        off = off + mw * mh * b;
        n++;
      end
    end
  endtask

  // per-cycle comparison against the model
  initial begin
    exp_cmd_t e;
    wait (run_mon);
    forever begin
      @(negedge clk);
      cmd_ready <= rand_rdy ? 1'($urandom % 3 != 0) : 1'b1;
      #1;
      // R9 R7: done exactly when due
      check(done == done_due, done_due ? "R9 done due" : "R9 spurious done",
            int'(done), int'(done_due));
      // R5 R10: command presence follows the model
      check(cmd_valid == (mbusy && !done_due && q.size() > 0), "R5 R10 valid",
            int'(cmd_valid), int'(mbusy && !done_due && q.size() > 0));
      if (cmd_valid && cmd_ready && q.size() > 0) begin
        e = q.pop_front();
        check(int'(cmd_x) == e.x, {e.tag, " x"}, int'(cmd_x), e.x);
        check(int'(cmd_y) == e.y, {e.tag, " y"}, int'(cmd_y), e.y);
        check(int'(cmd_w) == e.w, e.tag == "R2" ? "R1 width" : "R4 width", int'(cmd_w), e.w);
        check(int'(cmd_h) == e.h, e.tag == "R2" ? "R1 height" : "R4 height", int'(cmd_h), e.h);
        check(int'(cmd_off) == e.off, "R6 offset", int'(cmd_off), e.off);
        if (q.size() == 0) done_due = 1;
      end else if (done_due) begin
        done_due = 0;
        if (start) begin end // R10: start during the done cycle is ignored
        mbusy = 0;
        continue;
      end
      if (start && !mbusy) begin
        mbusy = 1;
        expect_upload(header);
        if (q.size() == 0) done_due = 1; // R7
      end
    end
  end

  task automatic upload(input logic [31:0] h);
    @(negedge clk);
    start  <= 1'b1;
    header <= h;
    @(negedge clk);
    start  <= 1'b0;
  endtask

  task automatic wait_idle();
    do begin
      @(negedge clk);
      #2;
    end while (mbusy);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 100000);
        finish_run();
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    #1;
    // R11
    check(cmd_valid == 1'b0, "R11 reset valid", int'(cmd_valid), 0);
    check(done == 1'b0, "R11 reset done", int'(done), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_mon = 1;

    // R5 mode 0, smallest size, stray bits set
    upload(mk(0, 0, 0, 0, 0, 0, 0, 4'hF)); wait_idle();
    // R3 largest size on the upper page, 16-bit texels
    upload(mk(0, 1, 7, 7, 1, 31, 63, 4'h0)); wait_idle();
    // R5 mode 1 only the base
    upload(mk(1, 0, 5, 3, 1, 3, 10, 4'h5)); wait_idle();
    // R6 mode 2 skips the base level, non-square
    upload(mk(2, 1, 3, 0, 0, 20, 5, 4'h0)); wait_idle();
    // R7 undefined modes
    upload(mk(5, 0, 2, 2, 0, 1, 1, 4'h0)); wait_idle();
    upload(mk(15, 1, 4, 4, 1, 2, 2, 4'h0)); wait_idle();

    // R8 back-pressure from here on
    rand_rdy = 1;
    upload(mk(0, 0, 1, 6, 0, 9, 40, 4'h3)); wait_idle();
    upload(mk(2, 0, 6, 2, 1, 17, 33, 4'h0)); wait_idle();

    // R10 a second start while busy is ignored
    upload(mk(0, 1, 2, 2, 1, 5, 7, 4'h0));
    repeat (2) @(negedge clk);
    upload(mk(1, 0, 0, 0, 0, 30, 60, 4'h0));
    wait_idle();
    upload(mk(0, 0, 4, 5, 0, 12, 21, 4'h0)); wait_idle();

    rand_rdy = 0;
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule